// File: doc/BRIEF.md
# Debug trigger state sequencer

This block walks a debug trigger through three intermediate states and one terminal Final state, driven by four comparator match lines. Each intermediate state owns a 4-bit routing code. The code says which match channel moves the sequencer, and to which state it moves. When several enabled matches arrive in the same cycle, a fixed priority resolver chooses one of them. Reaching Final raises a single-cycle trigger pulse, which a trace or halt unit elsewhere on the chip can consume.

Software programs the block through a small byte-wide register port. One register holds the control fields: the arm bit and a 2-bit page selector. A second register holds one enable bit per comparator. A third address is a window onto the routing code of the state chosen by the page selector. The routing codes are locked while the sequencer is armed, so a running sequence cannot be changed under it.

Top module: `trig_seq_top`

## Requirements
- R1: After reset the state output is State1 (2'b00), the armed output and the trigger output are low, and every register reads 0x00.
- R2: A match on channel n has an effect only while bit n of the enable register (address 1, bits 3:0) is set. A match on a disabled channel leaves the state unchanged.
- R3: In State2 (2'b01) the code routes as follows. 0000 sends any match to State1. 0011, 0100 and 0101 send match2 to State2, State3 (2'b10) and Final (2'b11) respectively. 0110 sends m0 to State2 and m1 to State3. 0111 sends m1 to State3 and m0 to Final. 1000 sends m0 to State2 and m2 to State3. 1001 sends m2 to State3 and m0 to Final. 1010 sends m1 to State2 and m3 to State3. 1011 sends m3 to State3 and m1 to Final. 1100 sends m0, m1 or m2 to State2. Every match not routed by the code is ignored.
- R4: Codes 0001, 0010 and 1101 to 1111 cause no transition for any match.
- R5: When several routed matches arrive together, a match bound for Final wins. Among the remaining matches, the lowest channel number wins.
- R6: State1 and State3 decode their own code registers (page 00 and page 10) with the same table as State2.
- R7: Writing the control register (address 0) with bit 0 set arms the sequencer and places it in State1. Writing it with bit 0 clear disarms it and places it in State1. While the sequencer is disarmed, matches have no effect.
- R8: On entering Final, the trigger output is high for exactly the first cycle in which the state output shows Final. At the same edge the armed flag clears, and the state stays Final until the control register is written.
- R9: Address 2 reads and writes the code of State1, State2 or State3 when the page field (control bits 5:4) is 00, 01 or 10. Page 11 reads zero and ignores writes. Code bits 7:4 read as zero. A code write made while the sequencer is armed leaves the code unchanged.
- R10: If a control write and a match bound for Final fall in the same cycle, the write wins. The state becomes State1, armed takes the written bit, and no trigger pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| match_i | input | 4 | Comparator match lines, channel 0 in bit 0 |
| state_o | output | 2 | Current state: 00 State1, 01 State2, 10 State3, 11 Final |
| armed_o | output | 1 | Sequencer armed |
| trig_o | output | 1 | One-cycle pulse on entering Final |

## Verification
Two functions can land on the same clock edge. One is a software write to the control register. The other is a match step that would otherwise carry the sequencer into Final and clear the armed flag. The bench provokes this by holding the sequencer in State2 with code 0101, then driving match2 and a control write with the arm bit set in the same cycle. It judges the result at the ports: the state must be State1, armed must be high, and the trigger must not pulse.

// File: rtl/trig_seq_pkg.sv
// Package: shared types and the routing table of the trigger sequencer.
// Assumes four match channels and a 4-bit routing code per state.
package trig_seq_pkg;

    localparam int CODE_W = 4;
    localparam int NUM_CH = 4;

    typedef enum logic [1:0] {
        ST_ONE   = 2'd0,
        ST_TWO   = 2'd1,
        ST_THREE = 2'd2,
        ST_FINAL = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       valid;
        seq_state_t tgt;
    } route_t;

    // Target of one channel under one routing code; valid low means ignored.
    function automatic route_t route_lookup(input logic [CODE_W-1:0] code,
                                            input int unsigned ch);
        route_t r;
        r.valid = 1'b0;
        r.tgt   = ST_ONE;
        case (code)
            4'h0: begin r.valid = 1'b1; r.tgt = ST_ONE; end
            4'h3: if (ch == 2) begin r.valid = 1'b1; r.tgt = ST_TWO;   end
            4'h4: if (ch == 2) begin r.valid = 1'b1; r.tgt = ST_THREE; end
            4'h5: if (ch == 2) begin r.valid = 1'b1; r.tgt = ST_FINAL; end
            4'h6: begin
                if (ch == 0) begin r.valid = 1'b1; r.tgt = ST_TWO;   end
                if (ch == 1) begin r.valid = 1'b1; r.tgt = ST_THREE; end
            end
            4'h7: begin
                if (ch == 1) begin r.valid = 1'b1; r.tgt = ST_THREE; end
                if (ch == 0) begin r.valid = 1'b1; r.tgt = ST_FINAL; end
            end
            4'h8: begin
                if (ch == 0) begin r.valid = 1'b1; r.tgt = ST_TWO;   end
                if (ch == 2) begin r.valid = 1'b1; r.tgt = ST_THREE; end
            end
            4'h9: begin
                if (ch == 2) begin r.valid = 1'b1; r.tgt = ST_THREE; end
                if (ch == 0) begin r.valid = 1'b1; r.tgt = ST_FINAL; end
            end
            4'hA: begin
                if (ch == 1) begin r.valid = 1'b1; r.tgt = ST_TWO;   end
                if (ch == 3) begin r.valid = 1'b1; r.tgt = ST_THREE; end
            end
            4'hB: begin
                if (ch == 3) begin r.valid = 1'b1; r.tgt = ST_THREE; end
                if (ch == 1) begin r.valid = 1'b1; r.tgt = ST_FINAL; end
            end
            4'hC: if (ch <= 2) begin r.valid = 1'b1; r.tgt = ST_TWO; end
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trig_seq_regs.sv
// Module: register bank of the trigger sequencer.
// Holds page select, comparator enables and three routing codes; decodes
// control writes for the core. Assumes reads are combinational on addr.
module trig_seq_regs
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              armed_i,
    output logic              ctl_wr_o,
    output logic              ctl_arm_o,
    output logic [NUM_CH-1:0] en_o,
    output logic [CODE_W-1:0] code_one_o,
    output logic [CODE_W-1:0] code_two_o,
    output logic [CODE_W-1:0] code_three_o
);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(2);
    localparam int PAGE_LSB = 4;

    logic [1:0]        page_q;
    logic [NUM_CH-1:0] en_q;
    logic [CODE_W-1:0] code_q [3];
    logic              code_wr;

    assign ctl_wr_o  = we_i && (addr_i == A_CTL);
    assign ctl_arm_o = wdata_i[0];
    assign code_wr   = we_i && (addr_i == A_CODE) && !armed_i && (page_q != 2'b11);

    // Page select and comparator enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= 2'b00;
            en_q   <= '0;
        end else begin
            if (ctl_wr_o)
                page_q <= wdata_i[PAGE_LSB+1:PAGE_LSB];
            if (we_i && (addr_i == A_EN))
                en_q <= wdata_i[NUM_CH-1:0];
        end
    end

    // One routing code register per intermediate state, locked while armed.
    for (genvar g = 0; g < 3; g++) begin : g_code
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q[g] <= '0;
            else if (code_wr && (page_q == 2'(g)))
                code_q[g] <= wdata_i[CODE_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTL: begin
                rdata_o[0] = armed_i;
                rdata_o[PAGE_LSB+1:PAGE_LSB] = page_q;
            end
            A_EN:   rdata_o[NUM_CH-1:0] = en_q;
            A_CODE: if (page_q != 2'b11) rdata_o[CODE_W-1:0] = code_q[page_q];
            default: rdata_o = '0;
        endcase
    end

    assign en_o         = en_q;
    assign code_one_o   = code_q[0];
    assign code_two_o   = code_q[1];
    assign code_three_o = code_q[2];

    // R9
    code_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && we_i && addr_i == A_CODE) |=> (code_q[0] == $past(code_q[0])
            && code_q[1] == $past(code_q[1]) && code_q[2] == $past(code_q[2])));

endmodule

// File: rtl/trig_seq_route.sv
// Module: next-state decode and simultaneous-match priority resolver.
// Assumes matches are already gated by their enable bits.
module trig_seq_route
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic [NUM_CH-1:0] match_i,
    output logic              hit_o,
    output seq_state_t        next_o
);

    logic       cand_v [NUM_CH];
    seq_state_t cand_t [NUM_CH];

    // Per-channel candidate target from the routing table.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cand
        route_t r;
        assign r         = route_lookup(code_i, c);
        assign cand_v[c] = r.valid && match_i[c];
        assign cand_t[c] = r.tgt;
    end

    // Lowest channel wins, then any Final-bound candidate overrides.
    always_comb begin
        hit_o  = 1'b0;
        next_o = ST_ONE;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (cand_v[c]) begin
                hit_o  = 1'b1;
                next_o = cand_t[c];
            end
        end
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (cand_v[c] && cand_t[c] == ST_FINAL)
                next_o = ST_FINAL;
        end
    end

    // R4
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 4'h1 || code_i == 4'h2 || code_i >= 4'hD) |-> !hit_o);

    // R2
    no_match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i == '0) |-> !hit_o);

endmodule

// File: rtl/trig_seq_core.sv
// Module: state register, armed flag and trigger pulse of the sequencer.
// Assumes a control write takes precedence over any match step.
module trig_seq_core
    import trig_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr_i,
    input  logic       ctl_arm_i,
    input  logic       hit_i,
    input  seq_state_t next_i,
    output seq_state_t state_o,
    output logic       armed_o,
    output logic       trig_o
);

    seq_state_t st_q;
    logic       armed_q;
    logic       trig_q;

    // Step the sequencer, handle arm writes and the Final pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_ONE;
            armed_q <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (ctl_wr_i) begin
                st_q    <= ST_ONE;
                armed_q <= ctl_arm_i;
            end else if (armed_q && hit_i) begin
                st_q <= next_i;
                if (next_i == ST_FINAL) begin
                    armed_q <= 1'b0;
                    trig_q  <= 1'b1;
                end
            end
        end
    end

    assign state_o = st_q;
    assign armed_o = armed_q;
    assign trig_o  = trig_q;

    // R8
    trig_in_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> (st_q == ST_FINAL && !armed_q));

    // R8
    trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q);

    // R7
    ctl_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (st_q == ST_ONE && !trig_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !ctl_wr_i) |=> $stable(st_q));

endmodule

// File: rtl/trig_seq_top.sv
// Module: top of the debug trigger sequencer.
// Gates matches by their enables, picks the code of the current state and
// connects register bank, route resolver and core.
module trig_seq_top
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] match_i,
    output logic [1:0]        state_o,
    output logic              armed_o,
    output logic              trig_o
);

    logic              ctl_wr, ctl_arm, armed, hit;
    logic [NUM_CH-1:0] en, gated;
    logic [CODE_W-1:0] code1, code2, code3, code_sel;
    seq_state_t        nxt, st;

    trig_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .armed_i(armed),
        .ctl_wr_o(ctl_wr), .ctl_arm_o(ctl_arm), .en_o(en),
        .code_one_o(code1), .code_two_o(code2), .code_three_o(code3)
    );

    assign gated = match_i & en;

    // Select the routing code of the current state.
    always_comb begin
        case (st)
            ST_ONE:   code_sel = code1;
            ST_TWO:   code_sel = code2;
            ST_THREE: code_sel = code3;
            default:  code_sel = 4'hF;
        endcase
    end

    trig_seq_route u_route (
        .clk(clk), .rst_n(rst_n), .code_i(code_sel), .match_i(gated),
        .hit_o(hit), .next_o(nxt)
    );

    trig_seq_core u_core (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_arm_i(ctl_arm),
        .hit_i(hit), .next_i(nxt), .state_o(st), .armed_o(armed),
        .trig_o(trig_o)
    );

    assign state_o = st;
    assign armed_o = armed;

endmodule

// File: tb/trig_seq_top_test.sv
module trig_seq_top_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 21;
    // {code[3:0], matches[3:0], expected state[1:0]} applied while in State2
    localparam logic [9:0] VEC [NV] = '{
        {4'h0, 4'b0100, 2'd0}, {4'h0, 4'b1000, 2'd0}, {4'h3, 4'b0100, 2'd1},
        {4'h4, 4'b0001, 2'd1}, {4'h4, 4'b0100, 2'd2}, {4'h5, 4'b0100, 2'd3},
        {4'h6, 4'b0001, 2'd1}, {4'h6, 4'b0010, 2'd2}, {4'h6, 4'b0011, 2'd1},
        {4'h7, 4'b0011, 2'd3}, {4'h8, 4'b0100, 2'd2}, {4'h9, 4'b0101, 2'd3},
        {4'hA, 4'b1000, 2'd2}, {4'hA, 4'b1010, 2'd1}, {4'hB, 4'b0010, 2'd3},
        {4'hB, 4'b1000, 2'd2}, {4'hC, 4'b1000, 2'd1}, {4'hC, 4'b0010, 2'd1},
        {4'h1, 4'b1111, 2'd1}, {4'hD, 4'b1111, 2'd1}, {4'hF, 4'b1111, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] match_i = '0;
    logic [1:0] state_o;
    logic       armed_o, trig_o;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trig_seq_top uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_i(match_i),
        .state_o(state_o), .armed_o(armed_o), .trig_o(trig_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // drive one match cycle; on return we are at the negedge after the edge
    task automatic step(input logic [3:0] m);
        @(negedge clk);
        match_i = m;
        @(negedge clk);
        match_i = '0;
    endtask

    // disarm, set State1 code 0011 and State2 code, arm, go to State2
    task automatic to_two(input logic [3:0] code2);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h10);
        wr(2'd2, {4'h0, code2});
        wr(2'd0, 8'h11);
        step(4'b0100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 state", {6'b0, state_o}, 8'h00);
        chk("R1 armed/trig", {6'b0, armed_o, trig_o}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 8'h00);
        end

        wr(2'd1, 8'h0F);
        // R3 R4 R5 table walk in State2
        for (int i = 0; i < NV; i++) begin
            to_two(VEC[i][9:6]);
            chk("R3 reach State2", {6'b0, state_o}, 8'h01);
            @(negedge clk);
            match_i = VEC[i][5:2];
            @(negedge clk);
            match_i = '0;
            chk("R3 R4 R5 vector state", {6'b0, state_o}, {6'b0, VEC[i][1:0]});
            chk("R8 trig with vector", {7'b0, trig_o}, {7'b0, VEC[i][1:0] == 2'd3});
        end

        // R8 stays Final, pulse one cycle, armed cleared
        to_two(4'h5);
        step(4'b0100);
        chk("R8 final", {6'b0, state_o}, 8'h03);
        chk("R8 pulse", {7'b0, trig_o}, 8'h01);
        chk("R8 armed clear", {7'b0, armed_o}, 8'h00);
        step(4'b1111);
        chk("R8 stay final", {6'b0, state_o}, 8'h03);
        chk("R8 pulse over", {7'b0, trig_o}, 8'h00);

        // R2 disabled channel ignored
        to_two(4'h4);
        wr(2'd1, 8'h0B);
        step(4'b0100);
        chk("R2 gated match", {6'b0, state_o}, 8'h01);
        wr(2'd1, 8'h0F);

        // R6 State1 code (page 00) routes m2 straight to Final
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h01);
        step(4'b0100);
        chk("R6 State1 code", {6'b0, state_o}, 8'h03);

        // R6 State3 code (page 10): reach State3 then 0000 returns to State1
        wr(2'd0, 8'h20);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h10);
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h01);
        step(4'b0100);
        step(4'b0100);
        chk("R6 at State3", {6'b0, state_o}, 8'h02);
        step(4'b1000);
        chk("R6 State3 code", {6'b0, state_o}, 8'h00);

        // R7 disarmed: no steps; disarm write returns to State1
        wr(2'd0, 8'h00);
        chk("R7 disarm", {6'b0, armed_o, 1'b0}, 8'h00);
        step(4'b0100);
        chk("R7 idle", {6'b0, state_o}, 8'h00);

        // R9 lock, upper bits, page 11
        wr(2'd0, 8'h10);
        wr(2'd2, 8'hF6);
        rd(2'd2, d);
        chk("R9 upper zero", d, 8'h06);
        wr(2'd0, 8'h11);
        wr(2'd2, 8'h09);
        rd(2'd2, d);
        chk("R9 lock", d, 8'h06);
        rd(2'd0, d);
        chk("R9 ctl read", d, 8'h11);
        wr(2'd0, 8'h30);
        wr(2'd2, 8'h0A);
        rd(2'd2, d);
        chk("R9 page11", d, 8'h00);

        // R10 control write and Final-bound match in one cycle
        to_two(4'h5);
        @(negedge clk);
        match_i = 4'b0100;
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h11;
        @(negedge clk);
        match_i = '0; bus_we = 1'b0;
        chk("R10 state", {6'b0, state_o}, 8'h00);
        chk("R10 armed", {7'b0, armed_o}, 8'h01);
        chk("R10 no pulse", {7'b0, trig_o}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule